// File: doc/BRIEF.md
# JTAG Host Scan Sequencer

This block is a host-side master for a JTAG test port. It drives the test clock, mode-select and data-in lines, and it samples data-out. A single command runs a whole scan operation. The block assumes the target is parked in Run-Test/Idle when a scan command starts. Three operations exist:

- A five-clock reset walk.
- An instruction load of N bits.
- A data-register access of N bits, which writes and reads at the same time.

The block walks the target state machine using fixed mode-select patterns on entry and on exit, and it runs a variable-length serial shift between them. Mode-select is never driven by software one bit at a time.

The host side latches the following with a one-cycle command strobe:

- an operation code;
- a bit count;
- a write vector, sent least significant bit first;
- a half-period divider.

Busy covers the whole operation. Done pulses once at the end. The read vector then holds the captured data-out bits, least significant bit first.

Top module: `jscan_host`

## Requirements
- R1: After synchronous reset, and whenever idle, tck, tms and tdi are 0, busy and done are 0, and rd_data is 0 after reset.
- R2: Operation code 0 (reset walk) produces exactly five rising tck edges, with tms=1 at each of them. This leaves the target in Test-Logic-Reset.
- R3: Operation code 1 (instruction load) presents tms 1,1,0,0 on the first four rising edges. It then shifts cmd_len bits into the instruction path, and tdi carries cmd_wdata bit k on shift edge k (least significant bit first).
- R4: Operation code 2 (data access) presents tms 1,0,0 on the first three rising edges. It then shifts cmd_len bits, with tdi taken from cmd_wdata least significant bit first. For both scan operations, rd_data bit k holds the tdo value sampled during tck-high of shift bit k, and bits at cmd_len and above are 0.
- R5: Every scan ends in the same way:
  - The last shift bit is clocked with tms=1.
  - It is followed by tms 0,1,1,0.
  - The total rising-edge count is the entry length plus cmd_len plus 4.
  - The target ends in Run-Test/Idle.
- R6: While busy, every tck high phase and every tck low phase lasts exactly D system clocks, where D is cmd_div, or 1 when cmd_div is 0. tms and tdi never change while tck is high.
- R7: Busy rises on the clock edge that accepts a command. It stays high for (2E+1)·D clocks, where E is the number of rising tck edges. Done is high for exactly one cycle, on the edge where busy falls.
- R8: A command strobe that arrives while busy is ignored. The running operation keeps its edge count and tms pattern, and no further operation starts.
- R9: The block ignores, and leaves busy low with no tck edge, any of the following:
  - operation code 3;
  - a scan operation with cmd_len of 0;
  - a scan operation with cmd_len greater than MAXLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 reset walk, 1 instruction load, 2 data access, 3 reserved |
| cmd_len | input | LEN_W | Shift bit count, 1..MAXLEN |
| cmd_wdata | input | MAXLEN | Write vector, bit 0 shifted first |
| cmd_div | input | DIV_W | tck half-period in system clocks (0 acts as 1) |
| tdo | input | 1 | Serial data from target |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to target |
| rd_data | output | MAXLEN | Captured tdo bits, bit 0 first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench connects the block to a behavioural target state machine that has a 4-bit instruction path and a 32-bit data path. It targets the following corner cases:

- One-bit scans, where the exit bit is also the first shift bit. A design that adds a separate exit clock would shift N+1 bits and leave the target in Pause.
- Full-width 32-bit scans, which catch an off-by-one in the position mask or in the write shifter.
- A divider of 0, where a naive counter would wrap to 256-clock phases.
- A strobe issued mid-operation, which would corrupt the running walk if it were accepted.
- Illegal lengths and the reserved code, which must produce no tck edge at all.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    typedef enum logic [1:0] {
        OP_TRST  = 2'd0,
        OP_IRLD  = 2'd1,
        OP_DRACC = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SHIFT,
        ST_POST,
        ST_TAIL
    } stage_e;

    // bits clocked after the exit bit (which rides on the last shift bit)
    localparam logic [2:0] POST_LAST = 3'd3;

    // number of entry-walk bits for each operation
    function automatic logic [2:0] pre_count(op_e op);
        case (op)
            OP_TRST:  return 3'd5;
            OP_IRLD:  return 3'd4;
            OP_DRACC: return 3'd3;
            default:  return 3'd1;
        endcase
    endfunction

    // tms value for entry-walk bit k
    function automatic logic pre_tms(op_e op, logic [2:0] k);
        case (op)
            OP_TRST:  return 1'b1;
            OP_IRLD:  return (k < 3'd2);
            OP_DRACC: return (k == 3'd0);
            default:  return 1'b0;
        endcase
    endfunction

    // tms value for exit-walk bit k (Pause, Exit2, Update, Idle)
    function automatic logic post_tms(logic [2:0] k);
        return (k == 3'd1) || (k == 3'd2);
    endfunction

endpackage

// File: rtl/jscan_tick.sv
module jscan_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_m1);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: phase counter never passes the programmed half-period
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div_m1));

endmodule

// File: rtl/jscan_shreg.sv
module jscan_shreg #(
    parameter int MAXLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MAXLEN-1:0] wr_data,
    input  logic              step,
    input  logic              tdo,
    output logic              cur_bit,
    output logic              nxt_bit,
    output logic [MAXLEN-1:0] rd_data
);
    logic [MAXLEN-1:0] wr_sh;
    logic [MAXLEN-1:0] pos;
    logic [MAXLEN-1:0] rd_q;

    assign cur_bit = wr_sh[0];
    assign nxt_bit = wr_sh[1];
    assign rd_data = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_sh <= '0;
            pos   <= '0;
            rd_q  <= '0;
        end else if (load) begin
            wr_sh <= wr_data;
            pos   <= {{(MAXLEN-1){1'b0}}, 1'b1};
            rd_q  <= '0;
        end else if (step) begin
            wr_sh <= wr_sh >> 1;
            pos   <= pos << 1;
            if (tdo) begin
                rd_q <= rd_q | pos;
            end
        end
    end

    // R4: exactly one capture slot at a time, never more
    assert_pos_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pos));

    // R4: a fresh command clears the read vector
    assert_rd_clear_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (rd_q == '0));

endmodule

// File: rtl/jscan_seq.sv
module jscan_seq
    import jscan_pkg::*;
#(
    parameter int MAXLEN = 32,
    parameter int LEN_W  = 6,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [DIV_W-1:0] cmd_div,
    input  logic             tick,
    input  logic             cur_bit,
    input  logic             nxt_bit,
    output logic [DIV_W-1:0] div_m1,
    output logic             load,
    output logic             step,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             busy,
    output logic             done
);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAXLEN);

    op_e              op_in;
    op_e              op_q;
    stage_e           st;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] idx;
    logic [2:0]       walk;
    logic             half;
    logic             legal;

    assign op_in = op_e'(cmd_op);
    assign legal = (op_in == OP_TRST) ||
                   ((op_in != OP_RSVD) && (cmd_len != '0) && (cmd_len <= MAX_L));
    assign load  = cmd_valid && !busy && legal;
    assign step  = tick && half && (st == ST_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op_q   <= OP_TRST;
            len_q  <= '0;
            idx    <= '0;
            walk   <= '0;
            half   <= 1'b0;
            div_m1 <= '0;
            tck    <= 1'b0;
            tms    <= 1'b0;
            tdi    <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (st == ST_IDLE) begin
                if (load) begin
                    st     <= ST_PRE;
                    op_q   <= op_in;
                    len_q  <= cmd_len;
                    idx    <= '0;
                    walk   <= '0;
                    half   <= 1'b0;
                    div_m1 <= (cmd_div == '0) ? '0 : cmd_div - 1'b1;
                    tms    <= pre_tms(op_in, 3'd0);
                    tdi    <= 1'b0;
                    busy   <= 1'b1;
                end
            end else if (tick) begin
                if (st == ST_TAIL) begin
                    st   <= ST_IDLE;
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (!half) begin
                    tck  <= 1'b1;
                    half <= 1'b1;
                end else begin
                    tck  <= 1'b0;
                    half <= 1'b0;
                    case (st)
                        ST_PRE: begin
                            if (walk == pre_count(op_q) - 3'd1) begin
                                if (op_q == OP_TRST) begin
                                    st  <= ST_TAIL;
                                    tms <= 1'b0;
                                end else begin
                                    st  <= ST_SHIFT;
                                    idx <= '0;
                                    tms <= (len_q == LEN_W'(1));
                                    tdi <= cur_bit;
                                end
                            end else begin
                                walk <= walk + 3'd1;
                                tms  <= pre_tms(op_q, walk + 3'd1);
                            end
                        end
                        ST_SHIFT: begin
                            if (idx == len_q - 1'b1) begin
                                st   <= ST_POST;
                                walk <= '0;
                                tms  <= post_tms(3'd0);
                                tdi  <= 1'b0;
                            end else begin
                                idx <= idx + 1'b1;
                                tms <= ((idx + 1'b1) == (len_q - 1'b1));
                                tdi <= nxt_bit;
                            end
                        end
                        ST_POST: begin
                            if (walk == POST_LAST) begin
                                st  <= ST_TAIL;
                                tms <= 1'b0;
                            end else begin
                                walk <= walk + 3'd1;
                                tms  <= post_tms(walk + 3'd1);
                            end
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // R6: pin setup only while the clock is low
    assert_stable_high_R6: assert property (@(posedge clk) disable iff (rst)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi)));

    // R1: the clock rests low whenever no operation runs
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tck);

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: done coincides with the fall of busy
    assert_done_end_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8: a strobe during an operation leaves the latched command alone
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> ($stable(op_q) && $stable(len_q)));

endmodule

// File: rtl/jscan_host.sv
module jscan_host #(
    parameter int MAXLEN = 32,
    parameter int DIV_W  = 8,
    localparam int LEN_W = $clog2(MAXLEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [MAXLEN-1:0] cmd_wdata,
    input  logic [DIV_W-1:0]  cmd_div,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic [MAXLEN-1:0] rd_data,
    output logic              busy,
    output logic              done
);
    logic             tick;
    logic             load;
    logic             step;
    logic             cur_bit;
    logic             nxt_bit;
    logic [DIV_W-1:0] div_m1;

    jscan_seq #(
        .MAXLEN (MAXLEN),
        .LEN_W  (LEN_W),
        .DIV_W  (DIV_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_len   (cmd_len),
        .cmd_div   (cmd_div),
        .tick      (tick),
        .cur_bit   (cur_bit),
        .nxt_bit   (nxt_bit),
        .div_m1    (div_m1),
        .load      (load),
        .step      (step),
        .tck       (tck),
        .tms       (tms),
        .tdi       (tdi),
        .busy      (busy),
        .done      (done)
    );

    jscan_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run    (busy),
        .div_m1 (div_m1),
        .tick   (tick)
    );

    jscan_shreg #(
        .MAXLEN (MAXLEN)
    ) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .wr_data (cmd_wdata),
        .step    (step),
        .tdo     (tdo),
        .cur_bit (cur_bit),
        .nxt_bit (nxt_bit),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sim_jscan_host.sv
module sim_jscan_host;

    localparam int MAXLEN = 32;
    localparam int DIV_W  = 8;
    localparam int LEN_W  = 6;
    localparam logic [3:0]  IR_CAP  = 4'b0101;
    localparam logic [31:0] DR_INIT = 32'hA5C3_1E69;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [MAXLEN-1:0] cmd_wdata = '0;
    logic [DIV_W-1:0]  cmd_div = '0;
    logic              tdo = 1'b0;
    logic              tck, tms, tdi, busy, done;
    logic [MAXLEN-1:0] rd_data;

    always #4 clk = ~clk;

    jscan_host #(.MAXLEN(MAXLEN), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .cmd_div(cmd_div),
        .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi), .rd_data(rd_data),
        .busy(busy), .done(done)
    );

    // ---------------- behavioural target ----------------
    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SDRS, T_CDR, T_SDR, T_E1DR, T_PDR, T_E2DR, T_UDR,
        T_SIRS, T_CIR, T_SIR, T_E1IR, T_PIR, T_E2IR, T_UIR
    } tap_e;

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR:  return m ? T_TLR  : T_RTI;
            T_RTI:  return m ? T_SDRS : T_RTI;
            T_SDRS: return m ? T_SIRS : T_CDR;
            T_CDR:  return m ? T_E1DR : T_SDR;
            T_SDR:  return m ? T_E1DR : T_SDR;
            T_E1DR: return m ? T_UDR  : T_PDR;
            T_PDR:  return m ? T_E2DR : T_PDR;
            T_E2DR: return m ? T_UDR  : T_SDR;
            T_UDR:  return m ? T_SDRS : T_RTI;
            T_SIRS: return m ? T_TLR  : T_CIR;
            T_CIR:  return m ? T_E1IR : T_SIR;
            T_SIR:  return m ? T_E1IR : T_SIR;
            T_E1IR: return m ? T_UIR  : T_PIR;
            T_PIR:  return m ? T_E2IR : T_PIR;
            T_E2IR: return m ? T_UIR  : T_SIR;
            default: return m ? T_SDRS : T_RTI;
        endcase
    endfunction

    tap_e        ts = T_RTI;
    logic [3:0]  ir_sh = '0, ir_val = '0;
    logic [31:0] dr_sh = '0, dr_val = DR_INIT;
    logic [63:0] tms_log = '0, tdi_log = '0;
    int          edges = 0, nshift = 0;

    always @(posedge tck) begin
        edges   <= edges + 1;
        tms_log <= {tms_log[62:0], tms};
        case (ts)
            T_CIR: ir_sh <= IR_CAP;
            T_SIR: begin
                ir_sh   <= {tdi, ir_sh[3:1]};
                tdi_log <= {tdi, tdi_log[63:1]};
                nshift  <= nshift + 1;
            end
            T_UIR: ir_val <= ir_sh;
            T_CDR: dr_sh <= dr_val;
            T_SDR: begin
                dr_sh   <= {tdi, dr_sh[31:1]};
                tdi_log <= {tdi, tdi_log[63:1]};
                nshift  <= nshift + 1;
            end
            T_UDR: dr_val <= dr_sh;
            default: ;
        endcase
        ts <= tap_next(ts, tms);
    end

    always @(negedge tck) begin
        tdo <= (ts == T_SIR) ? ir_sh[0] : (ts == T_SDR) ? dr_sh[0] : 1'b0;
    end

    // ---------------- pin monitor ----------------
    logic p_tck = 0, p_tms = 0, p_tdi = 0, p_busy = 0;
    int   viol = 0, busy_cnt = 0, done_cnt = 0, run_len = 0;
    int   rmin = 0, rmax = 0;

    always @(negedge clk) begin
        if (p_tck && tck && (tms != p_tms || tdi != p_tdi)) viol <= viol + 1;
        if (busy) busy_cnt <= busy_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (busy && !p_busy) begin
            run_len = 1;
            rmin    = 1000000;
            rmax    = 0;
        end else if (busy && tck == p_tck) begin
            run_len = run_len + 1;
        end else if (p_busy) begin
            if (run_len < rmin) rmin = run_len;
            if (run_len > rmax) rmax = run_len;
            run_len = 1;
        end
        p_tck  <= tck;
        p_tms  <= tms;
        p_tdi  <= tdi;
        p_busy <= busy;
    end

    // ---------------- checking ----------------
    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void exp_walk(input int op, input int n,
                                     output logic [63:0] s, output int e);
        s = '0;
        e = 0;
        if (op == 0) begin
            for (int k = 0; k < 5; k++) begin s = {s[62:0], 1'b1}; e++; end
        end else begin
            if (op == 1) begin
                s = {s[59:0], 4'b1100}; e += 4;
            end else begin
                s = {s[60:0], 3'b100}; e += 3;
            end
            for (int k = 0; k < n; k++) begin s = {s[62:0], (k == n - 1)}; e++; end
            s = {s[59:0], 4'b0110}; e += 4;
        end
    endfunction

    logic [3:0]  exp_ir = '0;
    logic [31:0] exp_dr = DR_INIT;

    task automatic pulse_cmd(input int op, input int n, input logic [31:0] wr, input int dv);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op[1:0];
        cmd_len   = n[LEN_W-1:0];
        cmd_wdata = wr;
        cmd_div   = dv[DIV_W-1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input int snap_done);
        int guard = 0;
        while (done_cnt == snap_done && guard < 20000) begin
            @(negedge clk); #1;
            guard++;
        end
        check(guard < 20000, "R7", "done timeout", 64'(guard), 64'd0);
        repeat (2) @(negedge clk);
        #1;
    endtask

    // full operation with all checks; interfere=1 adds a strobe while busy (R8)
    task automatic run_op(input int op, input int n, input logic [31:0] wr,
                          input int dv, input bit interfere);
        int e0, s0, b0, d0, v0, e_exp, dval, ws;
        logic [63:0] walk_exp, nmask, wmask, ext, rd_exp;
        string tg;
        tg = (op == 1) ? "R3" : (op == 2) ? "R4" : "R2";
        #1;
        e0 = edges; s0 = nshift; b0 = busy_cnt; d0 = done_cnt; v0 = viol;
        exp_walk(op, n, walk_exp, e_exp);
        dval  = (dv == 0) ? 1 : dv;
        pulse_cmd(op, n, wr, dv);
        if (interfere) begin
            repeat (5) @(negedge clk);
            pulse_cmd(1, 4, 32'hF, 1);
        end
        wait_done(d0);
        check(edges - e0 == e_exp, "R5", "edge count", 64'(edges - e0), 64'(e_exp));
        ws = (e_exp < 64) ? e_exp : 63;
        check((tms_log & ((64'd1 << ws) - 1)) == walk_exp, tg, "tms walk",
              tms_log & ((64'd1 << ws) - 1), walk_exp);
        check(busy_cnt - b0 == (2 * e_exp + 1) * dval, "R7", "busy length",
              64'(busy_cnt - b0), 64'((2 * e_exp + 1) * dval));
        check(done_cnt - d0 == 1, "R7", "done pulses", 64'(done_cnt - d0), 64'd1);
        check(rmin == dval && rmax == dval, "R6", "phase length",
              {32'(rmin), 32'(rmax)}, {32'(dval), 32'(dval)});
        check(viol == v0, "R6", "pin change while tck high", 64'(viol - v0), 64'd0);
        if (op == 0) begin
            check(ts == T_TLR, "R2", "target state", 64'(ts), 64'(T_TLR));
        end else begin
            nmask = (64'd1 << n) - 1;
            wmask = {32'd0, wr} & nmask;
            check(ts == T_RTI, "R5", "target state", 64'(ts), 64'(T_RTI));
            check(nshift - s0 == n, tg, "shift count", 64'(nshift - s0), 64'(n));
            check((tdi_log >> (64 - n)) == wmask, tg, "tdi bits",
                  tdi_log >> (64 - n), wmask);
            if (op == 1) begin
                ext    = (wmask << 4) | {60'd0, IR_CAP};
                exp_ir = ext[3:0] ;
                exp_ir = 4'(ext >> n);
                rd_exp = ext & nmask;
                check(ir_val == exp_ir, "R3", "instruction updated", 64'(ir_val), 64'(exp_ir));
            end else begin
                ext    = (wmask << 32) | {32'd0, exp_dr};
                exp_dr = 32'(ext >> n);
                rd_exp = ext & nmask;
                check(dr_val == exp_dr, "R4", "data register updated", 64'(dr_val), 64'(exp_dr));
            end
            check({32'd0, rd_data} == rd_exp, "R4", "read vector", 64'(rd_data), rd_exp);
        end
        if (interfere) begin
            b0 = busy_cnt;
            repeat (10) @(negedge clk);
            #1;
            check(busy_cnt == b0, "R8", "no extra operation", 64'(busy_cnt - b0), 64'd0);
        end
    endtask

    task automatic try_illegal(input int op, input int n);
        int e0, b0;
        #1;
        e0 = edges; b0 = busy_cnt;
        pulse_cmd(op, n, 32'hFFFF_FFFF, 1);
        repeat (6) @(negedge clk);
        #1;
        check(busy_cnt == b0 && edges == e0, "R9", "illegal command ignored",
              {32'(busy_cnt - b0), 32'(edges - e0)}, 64'd0);
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [5:0]  len;
        logic [31:0] wr;
        logic [7:0]  dv;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{2'd1, 6'd4,  32'h0000_000A, 8'd2},
        '{2'd2, 6'd32, 32'hDEAD_BEEF, 8'd1},
        '{2'd2, 6'd1,  32'h0000_0001, 8'd3},
        '{2'd1, 6'd7,  32'h0000_005B, 8'd0},
        '{2'd2, 6'd13, 32'h0000_1ABC, 8'd2},
        '{2'd1, 6'd1,  32'h0000_0000, 8'd4},
        '{2'd2, 6'd32, 32'h0F0F_1234, 8'd1}
    };

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        check({tck, tms, tdi, busy, done} == 5'b0, "R1", "pins after reset",
              64'({tck, tms, tdi, busy, done}), 64'd0);
        check(rd_data == '0, "R1", "read vector after reset", 64'(rd_data), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(int'(VT[i].op), int'(VT[i].len), VT[i].wr, int'(VT[i].dv), 1'b0);
        end

        // R8: strobe while busy
        run_op(2, 8, 32'h0000_00C6, 1, 1'b1);

        // R9: illegal commands
        try_illegal(3, 4);
        try_illegal(2, 0);
        try_illegal(1, 33);

        // R2: reset walk (leaves target in Test-Logic-Reset, so last)
        run_op(0, 0, 32'h0, 2, 1'b0);

        // R1: reset mid-operation returns pins to rest
        pulse_cmd(0, 0, 32'h0, 3);
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check({tck, tms, tdi, busy, done} == 5'b0, "R1", "pins after mid-op reset",
              64'({tck, tms, tdi, busy, done}), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule